// File: doc/BRIEF.md
# DRAM Area Configuration Register

This block is an 8-bit control register on a simple peripheral bus. A 3-bit area-select field decides which of four external address areas (areas 2, 3, 4 and 5) are treated as DRAM space. For each DRAM area, the field also picks the chip-select line (CS2 to CS5) that serves as its RAS strobe. Several areas may share one chip-select as a common RAS. A chip-select line that belongs to a DRAM area but is not used as any RAS is reported as released, so it can be handed over to general-purpose I/O. The remaining four bits hold mode controls for the DRAM timing engine: burst enable, RAS-down mode, self-refresh mode and refresh-pin output enable. The timing engine itself lies outside this block.

The block also decodes writes to four neighbouring registers: the second DRAM control register, the refresh timer control/status register, the refresh counter and the refresh constant register. While the chip runs in expanded mode and at least one area is DRAM space, the block suppresses the write strobes to those four registers. Even while this lock is active, writing 0 to the compare-match flag of the refresh timer control/status register still produces a flag-clear pulse.

The register returns to 0x10 on an asynchronous reset and on hardware-standby entry. A read returns the register value combinationally.

Top module: `dram_area_cfg`

## Requirements
- R1: After reset, and in the cycle after `hw_stby` is sampled high, `cfg_rdata` reads 0x10 and all decoded outputs show no DRAM areas. `hw_stby` has priority over a write in the same cycle.
- R2: A write with `wr_en`=1 and `sel`=0 loads bits 7:5 (area-select field) and bits 3:0 (bit 3 burst, bit 2 RAS-down, bit 1 self-refresh, bit 0 refresh output). Bit 4 ignores the written value and always reads 1.
- R3: `area_dram` (bit k = area k+2) follows the field: 000→0000, 001→0001, 010→0011, 011→0011, 100→0111, 101/110/111→1111.
- R4: `ras_sel` holds a 2-bit chip-select index per area at bits 2k+1:2k (0=CS2 … 3=CS5). Code 011 maps areas 2,3 to CS2. Code 110 maps areas 2,3 to CS2 and areas 4,5 to CS4. Code 111 maps all areas to CS2. Every other DRAM area uses its own chip-select, and a normal area reports its own index.
- R5: `cs_released` bit k is 1 exactly when area k+2 is DRAM space and no DRAM area uses CS(k+2) as RAS. Examples: code 011→0010, code 110→1010, code 111→1110.
- R6: `dram_lock` is 1 exactly when `expanded_mode` is 1 and the stored field is nonzero. `prot_wr` is one-hot on a write with `sel`=1..4 (bit `sel`-1), and it stays 0 while the lock is active.
- R7: The lock changes state in the cycle after the write that makes the field nonzero or zero, never in the write cycle itself.
- R8: `cmf_clr` pulses in any cycle with a write to `sel`=2 and data bit 7 equal to 0, whether or not the lock is active.
- R9: `burst_en`, `ras_down`, `self_refresh` and `refresh_out_en` equal stored bits 3, 2, 1 and 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| hw_stby | input | 1 | Hardware-standby entry; reloads the reset value |
| expanded_mode | input | 1 | Chip runs in expanded (external bus) mode |
| wr_en | input | 1 | Single-cycle write strobe |
| sel | input | 3 | Register select: 0 this register, 1 DRAM control B, 2 refresh timer CSR, 3 refresh counter, 4 refresh constant |
| wr_data | input | 8 | Write data |
| cfg_rdata | output | 8 | Register read value |
| area_dram | output | 4 | Per-area DRAM-space flag |
| ras_sel | output | 8 | Per-area RAS chip-select index |
| cs_released | output | 4 | Chip-select lines released to general I/O |
| burst_en | output | 1 | Burst access enable |
| ras_down | output | 1 | RAS-down mode |
| self_refresh | output | 1 | Self-refresh mode |
| refresh_out_en | output | 1 | Refresh pin output enable |
| dram_lock | output | 1 | Protected-register write lock active |
| prot_wr | output | 4 | Gated write strobes to the four protected registers |
| cmf_clr | output | 1 | Compare-match flag clear pulse |

## Verification
Each of the eight field codes is written in a directed pass and decoded. The shared codes 011, 110 and 111 are the only ones that separate a correct RAS-sharing and release decode from a plain per-area one. Random writes to all six select values, combined with toggling of expanded mode and standby, separate lock gating from ordinary strobe decoding. Directed lock sequences sample the lock just before and just after the edge, which shows whether it arrives one cycle late or too early. Writes to the timer status register with bit 7 at 0 and at 1 under the lock separate the flag-clear exception from a blanket block.

// File: rtl/dram_cfg_pkg.sv
package dram_cfg_pkg;
  localparam int AREA_N = 4;
  localparam int CS_W   = 2;
  localparam int FLD_W  = 3;
  localparam int MODE_W = 4;

  typedef logic [CS_W-1:0] cs_idx_t;

  typedef struct packed {
    logic [AREA_N-1:0]          dram;
    logic [AREA_N-1:0][CS_W-1:0] ras;
  } area_map_t;

  // Field decode: DRAM flags and RAS chip-select index per area.
  function automatic area_map_t map_field(input logic [FLD_W-1:0] f);
    area_map_t m;
    for (int k = 0; k < AREA_N; k++) m.ras[k] = cs_idx_t'(k);
    m.dram = '0;
    case (f)
      3'd1: m.dram = 4'b0001;
      3'd2: m.dram = 4'b0011;
      3'd3: begin m.dram = 4'b0011; m.ras[1] = 2'd0; end
      3'd4: m.dram = 4'b0111;
      3'd5: m.dram = 4'b1111;
      3'd6: begin
        m.dram = 4'b1111; m.ras[1] = 2'd0; m.ras[3] = 2'd2;
      end
      3'd7: begin
        m.dram = 4'b1111;
        for (int k = 0; k < AREA_N; k++) m.ras[k] = 2'd0;
      end
      default: m.dram = 4'b0000;
    endcase
    return m;
  endfunction
endpackage

// File: rtl/dram_rst_sync.sv
module dram_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb sync_d = {sync_q[STAGES-2:0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_n_sync = sync_q[STAGES-1];
endmodule

// File: rtl/dram_cfg_reg.sv
module dram_cfg_reg
  import dram_cfg_pkg::*;
#(
  parameter logic [FLD_W-1:0]  FIELD_RST = '0,
  parameter logic [MODE_W-1:0] MODE_RST  = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hw_stby,
  input  logic              we,
  input  logic [7:0]        wr_data,
  output logic [FLD_W-1:0]  field_q,
  output logic [MODE_W-1:0] mode_q,
  output logic [7:0]        rdata
);
  localparam logic RSVD_BIT = 1'b1;

  logic              load_en;
  logic [FLD_W-1:0]  field_d;
  logic [MODE_W-1:0] mode_d;

  always_comb begin
    load_en = hw_stby | we;
    field_d = field_q;
    mode_d  = mode_q;
    if (hw_stby) begin
      field_d = FIELD_RST;
      mode_d  = MODE_RST;
    end else if (we) begin
      field_d = wr_data[7:5];
      mode_d  = wr_data[3:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      field_q <= FIELD_RST;
      mode_q  <= MODE_RST;
    end else if (load_en) begin
      field_q <= field_d;
      mode_q  <= mode_d;
    end
  end

  assign rdata = {field_q, RSVD_BIT, mode_q};

  assert_stby_reload_R1: assert property (@(posedge clk) disable iff (!rst_n)
    hw_stby |=> (rdata == {FIELD_RST, 1'b1, MODE_RST}));

  assert_write_readback_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (we && !hw_stby) |=> (rdata == ($past(wr_data) | 8'h10)));
endmodule

// File: rtl/dram_area_decode.sv
module dram_area_decode
  import dram_cfg_pkg::*;
(
  input  logic [FLD_W-1:0]       field,
  output logic [AREA_N-1:0]      dram,
  output logic [AREA_N*CS_W-1:0] ras_flat,
  output logic [AREA_N-1:0]      released
);
  area_map_t map;
  logic [AREA_N-1:0] cs_used;

  always_comb map = map_field(field);

  assign dram     = map.dram;
  assign ras_flat = map.ras;

  for (genvar c = 0; c < AREA_N; c++) begin : g_cs
    always_comb begin
      cs_used[c] = 1'b0;
      for (int a = 0; a < AREA_N; a++)
        if (map.dram[a] && (map.ras[a] == cs_idx_t'(c))) cs_used[c] = 1'b1;
    end
    assign released[c] = map.dram[c] & ~cs_used[c];
  end
endmodule

// File: rtl/dram_wr_guard.sv
module dram_wr_guard
  import dram_cfg_pkg::*;
#(
  parameter int SEL_W = 3,
  parameter int PROT_N = 4,
  parameter logic [SEL_W-1:0] SEL_FIRST = 3'd1,
  parameter logic [SEL_W-1:0] SEL_TCSR  = 3'd2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [SEL_W-1:0]  sel,
  input  logic              flag_bit,
  input  logic [FLD_W-1:0]  field,
  input  logic              expanded_mode,
  output logic              lock,
  output logic [PROT_N-1:0] prot_wr,
  output logic              cmf_clr
);
  assign lock = expanded_mode & (field != '0);

  for (genvar i = 0; i < PROT_N; i++) begin : g_prot
    localparam logic [SEL_W-1:0] MY_SEL = SEL_FIRST + SEL_W'(i);
    assign prot_wr[i] = wr_en & (sel == MY_SEL) & ~lock;
  end

  assign cmf_clr = wr_en & (sel == SEL_TCSR) & ~flag_bit;

  assert_open_pass_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && sel == SEL_FIRST && !expanded_mode) |-> prot_wr[0]);

  assert_locked_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (expanded_mode && field != '0) |-> (prot_wr == '0));

  assert_flag_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && sel == SEL_TCSR && !flag_bit) |-> cmf_clr);
endmodule

// File: rtl/dram_area_cfg.sv
module dram_area_cfg
  import dram_cfg_pkg::*;
#(
  parameter int SEL_W = 3,
  parameter logic [SEL_W-1:0] SEL_CFG = 3'd0
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   hw_stby,
  input  logic                   expanded_mode,
  input  logic                   wr_en,
  input  logic [SEL_W-1:0]       sel,
  input  logic [7:0]             wr_data,
  output logic [7:0]             cfg_rdata,
  output logic [AREA_N-1:0]      area_dram,
  output logic [AREA_N*CS_W-1:0] ras_sel,
  output logic [AREA_N-1:0]      cs_released,
  output logic                   burst_en,
  output logic                   ras_down,
  output logic                   self_refresh,
  output logic                   refresh_out_en,
  output logic                   dram_lock,
  output logic [3:0]             prot_wr,
  output logic                   cmf_clr
);
  logic              rst_n_s;
  logic              cfg_we;
  logic [FLD_W-1:0]  field_q;
  logic [MODE_W-1:0] mode_q;

  dram_rst_sync #(.STAGES(2)) rsync_i (
    .clk(clk), .rst_n(rst_n), .rst_n_sync(rst_n_s));

  assign cfg_we = wr_en & (sel == SEL_CFG);

  dram_cfg_reg reg_i (
    .clk(clk), .rst_n(rst_n_s), .hw_stby(hw_stby), .we(cfg_we),
    .wr_data(wr_data), .field_q(field_q), .mode_q(mode_q),
    .rdata(cfg_rdata));

  dram_area_decode dec_i (
    .field(field_q), .dram(area_dram), .ras_flat(ras_sel),
    .released(cs_released));

  dram_wr_guard #(.SEL_W(SEL_W), .PROT_N(4)) guard_i (
    .clk(clk), .rst_n(rst_n_s), .wr_en(wr_en), .sel(sel),
    .flag_bit(wr_data[7]), .field(field_q),
    .expanded_mode(expanded_mode), .lock(dram_lock),
    .prot_wr(prot_wr), .cmf_clr(cmf_clr));

  assign burst_en       = mode_q[3];
  assign ras_down       = mode_q[2];
  assign self_refresh   = mode_q[1];
  assign refresh_out_en = mode_q[0];

  assert_lock_next_R7: assert property (@(posedge clk) disable iff (!rst_n_s)
    (cfg_we && !hw_stby && wr_data[7:5] != 3'd0 && expanded_mode)
      |=> (dram_lock || !expanded_mode));

  assert_unlock_next_R7: assert property (@(posedge clk) disable iff (!rst_n_s)
    (cfg_we && !hw_stby && wr_data[7:5] == 3'd0) |=> !dram_lock);

  assert_area2_ras_R4: assert property (@(posedge clk) disable iff (!rst_n_s)
    area_dram[0] |-> (ras_sel[1:0] == 2'd0));

  assert_release_subset_R5: assert property (@(posedge clk) disable iff (!rst_n_s)
    (cs_released & ~area_dram) == 4'b0000);

  assert_area_nesting_R3: assert property (@(posedge clk) disable iff (!rst_n_s)
    area_dram[3] |-> (area_dram[2:0] == 3'b111));
endmodule

// File: tb/dram_area_cfg_tb_top.sv
`timescale 1ns/1ps
module dram_area_cfg_tb_top;
  logic clk = 1'b0;
  logic rst_n, hw_stby, expanded_mode, wr_en;
  logic [2:0] sel;
  logic [7:0] wr_data, cfg_rdata;
  logic [3:0] area_dram, cs_released, prot_wr;
  logic [7:0] ras_sel;
  logic burst_en, ras_down, self_refresh, refresh_out_en, dram_lock, cmf_clr;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  logic [2:0] m_fld;
  logic [3:0] m_mode;

  always #5 clk = ~clk;

  dram_area_cfg dut_i (.*);

  function automatic logic [3:0] exp_dram(input logic [2:0] f);
    case (f)
      3'd0: return 4'b0000;
      3'd1: return 4'b0001;
      3'd2, 3'd3: return 4'b0011;
      3'd4: return 4'b0111;
      default: return 4'b1111;
    endcase
  endfunction

  function automatic logic [7:0] exp_ras(input logic [2:0] f);
    case (f)
      3'd3: return {2'd3, 2'd2, 2'd0, 2'd0};
      3'd6: return {2'd2, 2'd2, 2'd0, 2'd0};
      3'd7: return 8'h00;
      default: return {2'd3, 2'd2, 2'd1, 2'd0};
    endcase
  endfunction

  function automatic logic [3:0] exp_rel(input logic [2:0] f);
    case (f)
      3'd3: return 4'b0010;
      3'd6: return 4'b1010;
      3'd7: return 4'b1110;
      default: return 4'b0000;
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic check_state();
    logic [7:0] rd_e;
    rd_e = {m_fld, 1'b1, m_mode};
    check(cfg_rdata == rd_e, "R1/R2 readback", cfg_rdata, rd_e);
    check(area_dram == exp_dram(m_fld), "R3 area_dram", area_dram, exp_dram(m_fld));
    check(ras_sel == exp_ras(m_fld), "R4 ras_sel", ras_sel, exp_ras(m_fld));
    check(cs_released == exp_rel(m_fld), "R5 cs_released", cs_released, exp_rel(m_fld));
    check({burst_en, ras_down, self_refresh, refresh_out_en} == m_mode, "R9 mode bits",
          {burst_en, ras_down, self_refresh, refresh_out_en}, m_mode);
    check(dram_lock == (expanded_mode && m_fld != 0), "R6 dram_lock", dram_lock,
          (expanded_mode && m_fld != 0));
  endtask

  // One bus cycle: drive at negedge, check strobes, then state after the edge.
  task automatic cycle(input logic we, input logic [2:0] s, input logic [7:0] d,
                       input logic stby, input logic expm);
    logic lk;
    logic [3:0] pw_e;
    @(negedge clk);
    wr_en = we; sel = s; wr_data = d; hw_stby = stby; expanded_mode = expm;
    #1;
    lk = expm && (m_fld != 0);
    pw_e = (we && s >= 3'd1 && s <= 3'd4 && !lk) ? (4'b0001 << (s - 3'd1)) : 4'b0000;
    check(prot_wr == pw_e, "R6 prot_wr", prot_wr, pw_e);
    check(cmf_clr == (we && s == 3'd2 && !d[7]), "R8 cmf_clr", cmf_clr,
          (we && s == 3'd2 && !d[7]));
    check(dram_lock == lk, "R7 lock before edge", dram_lock, lk);
    @(posedge clk);
    if (stby) begin m_fld = 3'd0; m_mode = 4'd0; end
    else if (we && s == 3'd0) begin m_fld = d[7:5]; m_mode = d[3:0]; end
    #1;
    check_state();
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    rst_n = 1'b0; hw_stby = 0; expanded_mode = 1; wr_en = 0; sel = 0; wr_data = 0;
    m_fld = 0; m_mode = 0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    check(cfg_rdata == 8'h10, "R1 reset value", cfg_rdata, 8'h10);
    check_state();

    // R2: reserved bit and full readback
    cycle(1, 3'd0, 8'hEF, 0, 0);
    cycle(1, 3'd0, 8'h00, 0, 0);
    cycle(1, 3'd0, 8'h1F, 0, 0);

    // R3/R4/R5: every field code
    for (int f = 0; f < 8; f++) cycle(1, 3'd0, {f[2:0], 5'b0_1010}, 0, 0);

    // R7: lock timing and R6 gating
    cycle(1, 3'd0, 8'h20, 0, 1);
    cycle(1, 3'd1, 8'hAA, 0, 1);
    cycle(1, 3'd4, 8'h55, 0, 1);
    // R8: flag clear under lock, and bit 7 = 1 gives none
    cycle(1, 3'd2, 8'h7F, 0, 1);
    cycle(1, 3'd2, 8'h80, 0, 1);
    // R6: expanded mode off releases the lock
    cycle(1, 3'd3, 8'h12, 0, 0);
    // R7: unlock one cycle after field returns to 000
    cycle(1, 3'd0, 8'h00, 0, 1);
    cycle(1, 3'd3, 8'h34, 0, 1);
    // R1: standby beats a write in the same cycle
    cycle(1, 3'd0, 8'hFF, 0, 1);
    cycle(1, 3'd0, 8'hE5, 1, 1);

    // random mix
    for (int i = 0; i < 400; i++) begin
      logic [2:0] s;
      s = 3'($urandom_range(0, 5));
      cycle(1'($urandom_range(0, 3) != 0), s, 8'($urandom),
            1'($urandom_range(0, 24) == 0), 1'($urandom_range(0, 3) != 0));
    end

    @(negedge clk) wr_en = 0;
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule